// File: doc/BRIEF.md
# Single-Stream Peripheral DMA Engine

This block is one DMA stream. It moves data items between a fixed peripheral data register and a buffer in memory, one item for each request pulse from a peripheral. A channel selector picks which of the peripheral request lines drives the stream. Each item is moved in two single-beat bus phases on a simple master port with a ready handshake: a read from the source address, then a write to the destination address.

Software sets the stream up through a small word-addressed register port. It writes the peripheral address, the memory base, the item count and the control word, then sets the enable bit. The stream counts items down as they move. When the count runs out it raises a completion flag. In circular mode it rewinds and keeps serving requests; otherwise it disables itself. A bus error response raises an error flag and stops the stream. Both flags can drive one interrupt line, and each flag is cleared by writing a one to its own bit of a clear register.

Register map (word index on `regAddr`): 0 control, 1 count, 2 peripheral address, 3 memory base, 4 status (read), 5 flag clear (write). Control word bits: 0 enable, 1 completion interrupt enable, 2 error interrupt enable, 3 direction (0 = peripheral to memory, 1 = memory to peripheral), 4 peripheral increment, 5 memory increment, 7:6 peripheral size, 9:8 memory size, 10 circular, 13:11 channel select. Size codes are 0 = byte, 1 = halfword, 2 = word; code 3 behaves as word.

Top module: `dmaStream`

## Requirements
- R1: No bus request is issued while the enable bit is 0. A control write that sets enable while the programmed count is 0 is ignored, and enable reads back 0.
- R2: Only a rising edge on `periphReq[chsel]` starts an item, where chsel is control bits 13:11. Each such edge moves exactly one item: a read phase (`busWe`=0) and then a write phase (`busWe`=1). Edges on other request lines have no effect.
- R3: With direction 0 the read goes to the peripheral pointer and the write to the memory pointer; with direction 1 the two are swapped. After each item, a pointer whose increment flag is set advances by its side's item size (1, 2 or 4 bytes); otherwise it stays at its base.
- R4: The read phase uses the source side's size code on `busSize` and the write phase uses the destination side's. The written data is the read data masked to the source size (0xFF, 0xFFFF or all ones) and zero-extended.
- R5: The count register (index 1) reads the live remaining count. It is loaded from the programmed value on enable and drops by one after each item completes.
- R6: When the count reaches zero, status bit 0 (completion) is set. In non-circular mode the enable bit clears and later requests are ignored.
- R7: In circular mode, completion of the last item reloads the programmed count and returns both pointers to their bases. The enable bit stays 1, so the next requests repeat the same address sequence.
- R8: An error response on either phase sets status bit 1 (error) and clears enable. The item is not counted, and a failed read is followed by no write phase.
- R9: `irq` is high exactly when (completion flag and bit 1 of the control word) or (error flag and bit 2 of the control word).
- R10: Writing register 5 clears the completion flag for a 1 in bit 0 and the error flag for a 1 in bit 1. A 0 in a bit leaves that flag unchanged.
- R11: While enabled, writes to the count, the addresses and the control fields are ignored. A control write with bit 0 = 0 clears only the enable bit.
- R12: After reset every readable register is 0, `irq` is 0 and `busReq` is 0.
- R13: Once `busReq` is raised, it stays high with `busAddr`, `busWe` and `busSize` unchanged until a cycle with `busReady` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| periphReq | input | 8 | Peripheral request lines |
| busReq | output | 1 | Bus phase request |
| busWe | output | 1 | 1 = write phase, 0 = read phase |
| busAddr | output | 32 | Byte address of the phase |
| busSize | output | 2 | Size code of the phase |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, valid with `busReady` |
| busReady | input | 1 | Ends the current phase |
| busErr | input | 1 | Error response, valid with `busReady` |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume that the bus slave raises `busReady` only while `busReq` is high, and that each request line stays low long enough for every pulse to be seen as a fresh rising edge. They also assume a new pulse arrives only after the previous item has finished, because only one pending request is held. The stimulus gives each pulse two cycles and then waits for `busReq` to drop before it sends the next one. The bus model answers each phase after a random wait and never raises ready twice in a row. Errors are injected on one chosen phase at a time, and only while the stream is idle.

// File: rtl/dmaPkg.sv
package dmaPkg;
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_COUNT = 3'd1;
  localparam logic [2:0] RA_PADDR = 3'd2;
  localparam logic [2:0] RA_MADDR = 3'd3;
  localparam logic [2:0] RA_STAT  = 3'd4;
  localparam logic [2:0] RA_CLR   = 3'd5;

  localparam int B_EN = 0, B_TCIE = 1, B_TEIE = 2, B_DIR = 3, B_PINC = 4,
                 B_MINC = 5, B_PSIZE = 6, B_MSIZE = 8, B_CIRC = 10, B_CHSEL = 11;

  typedef struct packed {
    logic       dir;
    logic       pinc;
    logic       minc;
    logic [1:0] psize;
    logic [1:0] msize;
    logic       circ;
  } cfgT;

  typedef struct packed {
    logic load;
    logic capture;
    logic step;
    logic reload;
  } strbT;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} stateT;

  function automatic logic [2:0] stepOf(input logic [1:0] s);
    case (s)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dmaPath.sv
module dmaPath
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strbT              strb,
  input  cfgT               cfg,
  input  logic [ADDR_W-1:0] pBase,
  input  logic [ADDR_W-1:0] mBase,
  input  logic [CNT_W-1:0]  cntInit,
  input  logic              inRead,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [DATA_W-1:0] busWdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              lastItem
);
  logic [ADDR_W-1:0] pCur, mCur;
  logic [DATA_W-1:0] dataLatch;
  logic [1:0]        srcSize, dstSize;
  logic [ADDR_W-1:0] srcAddr, dstAddr;

  function automatic logic [DATA_W-1:0] maskOf(input logic [1:0] s);
    case (s)
      2'd0:    return DATA_W'(8'hFF);
      2'd1:    return DATA_W'(16'hFFFF);
      default: return '1;
    endcase
  endfunction

  always_comb begin
    srcSize  = cfg.dir ? cfg.msize : cfg.psize;
    dstSize  = cfg.dir ? cfg.psize : cfg.msize;
    srcAddr  = cfg.dir ? mCur : pCur;
    dstAddr  = cfg.dir ? pCur : mCur;
    busAddr  = inRead ? srcAddr : dstAddr;
    busSize  = inRead ? srcSize : dstSize;
    busWdata = dataLatch;
    lastItem = (cnt == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pCur      <= '0;
      mCur      <= '0;
      cnt       <= '0;
      dataLatch <= '0;
    end else begin
      if (strb.load || strb.reload) begin
        pCur <= pBase;
        mCur <= mBase;
        cnt  <= cntInit;
      end else if (strb.step) begin
        if (cfg.pinc) pCur <= pCur + ADDR_W'(stepOf(cfg.psize));
        if (cfg.minc) mCur <= mCur + ADDR_W'(stepOf(cfg.msize));
        cnt <= cnt - CNT_W'(1);
      end
      if (strb.capture) dataLatch <= busRdata & maskOf(srcSize);
    end
  end

  // R5: one completed item lowers the live count by exactly one
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> cnt == $past(cnt) - CNT_W'(1));

  // R3: a pointer without its increment flag keeps its address
  a_r3_fixed_ptr: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && !cfg.pinc |=> pCur == $past(pCur));

  // R7: circular wrap restores count and memory pointer
  a_r7_rewind: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> cnt == $past(cntInit) && mCur == $past(mBase));
endmodule

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int NUM_REQ = 8,
  localparam int SEL_W  = $clog2(NUM_REQ)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [NUM_REQ-1:0] periphReq,
  output logic              busReq,
  output logic              busWe,
  input  logic              busReady,
  input  logic              busErr,
  output logic              irq,
  output cfgT               cfg,
  output logic [ADDR_W-1:0] pBase,
  output logic [ADDR_W-1:0] mBase,
  output logic [CNT_W-1:0]  cntInit,
  output strbT              strb,
  output logic              inRead,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              lastItem
);
  stateT            state;
  logic             en, tcie, teie, tcF, teF;
  logic [SEL_W-1:0] chsel;
  logic             reqPrev, pending, reqSel, reqRise;
  logic             wrCtrl, wrCnt, wrPad, wrMad, wrClr;
  logic             startEn, done, okRead, okWrite, errHit;
  logic [DATA_W-1:0] ctrlWord;

  always_comb begin
    wrCtrl  = regWe && regAddr == RA_CTRL;
    wrCnt   = regWe && regAddr == RA_COUNT && !en;
    wrPad   = regWe && regAddr == RA_PADDR && !en;
    wrMad   = regWe && regAddr == RA_MADDR && !en;
    wrClr   = regWe && regAddr == RA_CLR;
    startEn = wrCtrl && !en && regWdata[B_EN] && state == ST_IDLE &&
              cntInit != '0;
    reqSel  = periphReq[chsel];
    reqRise = reqSel && !reqPrev;
    done    = busReq && busReady;
    errHit  = done && busErr;
    okRead  = done && !busErr && state == ST_READ;
    okWrite = done && !busErr && state == ST_WRITE;
    busReq  = state != ST_IDLE;
    busWe   = state == ST_WRITE;
    inRead  = state == ST_READ;
    strb.load    = startEn;
    strb.capture = okRead;
    strb.step    = okWrite && !(lastItem && cfg.circ);
    strb.reload  = okWrite && lastItem && cfg.circ;
    irq = (tcF && tcie) || (teF && teie);
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[B_EN]   = en;
    ctrlWord[B_TCIE] = tcie;
    ctrlWord[B_TEIE] = teie;
    ctrlWord[B_DIR]  = cfg.dir;
    ctrlWord[B_PINC] = cfg.pinc;
    ctrlWord[B_MINC] = cfg.minc;
    ctrlWord[B_PSIZE +: 2] = cfg.psize;
    ctrlWord[B_MSIZE +: 2] = cfg.msize;
    ctrlWord[B_CIRC] = cfg.circ;
    ctrlWord[B_CHSEL +: SEL_W] = chsel;
    case (regAddr)
      RA_CTRL:  regRdata = ctrlWord;
      RA_COUNT: regRdata = DATA_W'(cnt);
      RA_PADDR: regRdata = DATA_W'(pBase);
      RA_MADDR: regRdata = DATA_W'(mBase);
      RA_STAT:  regRdata = DATA_W'({teF, tcF});
      default:  regRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      en      <= 1'b0;
      tcie    <= 1'b0;
      teie    <= 1'b0;
      cfg     <= '0;
      chsel   <= '0;
      pBase   <= '0;
      mBase   <= '0;
      cntInit <= '0;
      tcF     <= 1'b0;
      teF     <= 1'b0;
      reqPrev <= 1'b0;
      pending <= 1'b0;
    end else begin
      reqPrev <= reqSel;
      pending <= en && ((pending && state != ST_IDLE) || reqRise);

      case (state)
        ST_IDLE:  if (en && pending) state <= ST_READ;
        ST_READ:  if (done) state <= busErr ? ST_IDLE : ST_WRITE;
        default:  if (done) state <= ST_IDLE;
      endcase

      if (wrCtrl && !en) begin
        tcie      <= regWdata[B_TCIE];
        teie      <= regWdata[B_TEIE];
        cfg.dir   <= regWdata[B_DIR];
        cfg.pinc  <= regWdata[B_PINC];
        cfg.minc  <= regWdata[B_MINC];
        cfg.psize <= regWdata[B_PSIZE +: 2];
        cfg.msize <= regWdata[B_MSIZE +: 2];
        cfg.circ  <= regWdata[B_CIRC];
        chsel     <= regWdata[B_CHSEL +: SEL_W];
      end
      if (wrCnt) cntInit <= regWdata[CNT_W-1:0];
      if (wrPad) pBase   <= regWdata[ADDR_W-1:0];
      if (wrMad) mBase   <= regWdata[ADDR_W-1:0];

      if (errHit || (okWrite && lastItem && !cfg.circ) ||
          (wrCtrl && en && !regWdata[B_EN]))
        en <= 1'b0;
      else if (startEn)
        en <= 1'b1;

      if (okWrite && lastItem)             tcF <= 1'b1;
      else if (wrClr && regWdata[0])       tcF <= 1'b0;
      if (errHit)                          teF <= 1'b1;
      else if (wrClr && regWdata[1])       teF <= 1'b0;
    end
  end

  // R13: an unanswered phase keeps its request and kind
  a_r13_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busReady |=> busReq && $stable(busWe));

  // R8: an error response stops the stream and flags it
  a_r8_err_stop: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busReady && busErr |=> !en && teF);

  // R6: the final write of a one-shot run completes and disables
  a_r6_done_off: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busWe && busReady && !busErr && lastItem && !cfg.circ
    |=> !en && tcF);
endmodule

// File: rtl/dmaStream.sv
module dmaStream
  import dmaPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int NUM_REQ = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_REQ-1:0] periphReq,
  output logic               busReq,
  output logic               busWe,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [1:0]         busSize,
  output logic [DATA_W-1:0]  busWdata,
  input  logic [DATA_W-1:0]  busRdata,
  input  logic               busReady,
  input  logic               busErr,
  output logic               irq
);
  cfgT               cfg;
  strbT              strb;
  logic [ADDR_W-1:0] pBase, mBase;
  logic [CNT_W-1:0]  cntInit, cnt;
  logic              inRead, lastItem;

  dmaCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_REQ(NUM_REQ)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .periphReq(periphReq),
    .busReq(busReq), .busWe(busWe), .busReady(busReady), .busErr(busErr),
    .irq(irq), .cfg(cfg), .pBase(pBase), .mBase(mBase), .cntInit(cntInit),
    .strb(strb), .inRead(inRead), .cnt(cnt), .lastItem(lastItem));

  dmaPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .pBase(pBase),
    .mBase(mBase), .cntInit(cntInit), .inRead(inRead), .busRdata(busRdata),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata), .cnt(cnt),
    .lastItem(lastItem));
endmodule

// File: tb/tb_dmaStream.sv
module tb_dmaStream;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  periphReq = '0;
  logic        busReq, busWe;
  logic [31:0] busAddr, busWdata;
  logic [1:0]  busSize;
  logic [31:0] busRdata = '0;
  logic        busReady = 1'b0;
  logic        busErr = 1'b0;
  logic        irq;

  int nChk = 0;
  int nBad = 0;
  int errArm = 0;      // 1: fail next read, 2: fail next write
  int nRd = 0, nWr = 0;
  logic [31:0] rdA [512];
  logic [31:0] rdD [512];
  logic [1:0]  rdS [512];
  logic [31:0] wrA [512];
  logic [31:0] wrD [512];
  logic [1:0]  wrS [512];
  logic        lastReq = 1'b0, lastRdy = 1'b0;
  logic [31:0] lastAddr = '0;

  always #4 clk = ~clk;

  dmaStream dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .periphReq(periphReq),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .busErr(busErr), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // bus slave: random wait, never two ready cycles back to back
  always @(negedge clk) begin
    logic give;
    if (lastReq && !lastRdy) begin
      check("R13 request held", {31'd0, busReq}, 32'd1);
      check("R13 address held", busAddr, lastAddr);
    end
    give = busReq && !busReady && ($urandom % 3 != 0);
    busReady <= give;
    busErr   <= 1'b0;
    if (give) begin
      if (!busWe) begin
        if (errArm == 1) begin busErr <= 1'b1; errArm = 0; end
        else begin
          busRdata <= $urandom;
        end
      end else begin
        if (errArm == 2) begin busErr <= 1'b1; errArm = 0; end
        else if (nWr < 512) begin
          wrA[nWr] = busAddr; wrD[nWr] = busWdata; wrS[nWr] = busSize; nWr++;
        end
      end
    end
    lastReq  = busReq;
    lastRdy  = give;
    lastAddr = busAddr;
  end

  // log completed reads with the data actually returned
  always @(posedge clk) begin
    if (busReq && busReady && !busWe && !busErr && nRd < 512) begin
      rdA[nRd] = busAddr; rdD[nRd] = busRdata; rdS[nRd] = busSize; nRd++;
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic pulse(input int line);
    @(negedge clk); periphReq[line] = 1'b1;
    @(negedge clk); periphReq[line] = 1'b0;
    repeat (2) @(negedge clk);
    while (busReq) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] mkCtrl(input bit en, tcie, teie, dir, pinc, minc,
      input logic [1:0] ps, ms, input bit circ, input logic [2:0] ch);
    return {18'd0, ch, circ, ms, ps, minc, pinc, dir, teie, tcie, en};
  endfunction

  function automatic logic [31:0] bytesOf(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] maskOf(input logic [1:0] s);
    return (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic runRandom(input int idx);
    bit dir, pinc, minc, circ;
    logic [1:0] ps, ms, ss, ds;
    logic [2:0] ch;
    logic [31:0] pb, mb, sb, db, rv;
    bit si, di;
    int cntv, items, r0, w0;
    dir = idx[0]; circ = idx[1];
    pinc = $urandom % 2; minc = $urandom % 2;
    ps = 2'($urandom % 3); ms = 2'($urandom % 3);
    ch = 3'($urandom % 8);
    pb = {$urandom % 32'h10000, 2'b00} & 32'h0003_FFFC;
    mb = 32'h2000_0000 | ({$urandom % 32'h10000, 2'b00} & 32'h0003_FFFC);
    cntv = 1 + ($urandom % 4);
    items = circ ? 2 * cntv : cntv;
    regWrite(3'd1, cntv);
    regWrite(3'd2, pb);
    regWrite(3'd3, mb);
    r0 = nRd; w0 = nWr;
    regWrite(3'd0, mkCtrl(1, 1, 0, dir, pinc, minc, ps, ms, circ, ch));
    for (int i = 0; i < items; i++) pulse(ch);
    ss = dir ? ms : ps; ds = dir ? ps : ms;
    sb = dir ? mb : pb; db = dir ? pb : mb;
    si = dir ? minc : pinc; di = dir ? pinc : minc;
    check("R2 read count", nRd - r0, items);
    check("R2 write count", nWr - w0, items);
    for (int i = 0; i < items; i++) begin
      int k;
      k = i % cntv;
      check("R3 read address", rdA[r0+i], sb + (si ? k * bytesOf(ss) : 0));
      check("R3 write address", wrA[w0+i], db + (di ? k * bytesOf(ds) : 0));
      check("R4 read size", {30'd0, rdS[r0+i]}, {30'd0, ss});
      check("R4 write size", {30'd0, wrS[w0+i]}, {30'd0, ds});
      check("R4 write data", wrD[w0+i], rdD[r0+i] & maskOf(ss));
    end
    regRead(3'd1, rv);
    check(circ ? "R7 count reloaded" : "R5 count at zero", rv, circ ? cntv : 0);
    regRead(3'd4, rv);
    check("R6 completion flag", rv, 32'd1);
    check("R9 irq on completion", {31'd0, irq}, 32'd1);
    regRead(3'd0, rv);
    check(circ ? "R7 enable kept" : "R6 enable cleared", {31'd0, rv[0]}, {31'd0, circ});
    if (!circ) begin
      r0 = nRd;
      pulse(ch);
      check("R6 request after end ignored", nRd - r0, 0);
    end
    regWrite(3'd0, 32'd0);
    regWrite(3'd5, 32'd3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int r0, w0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), rv);
      check("R12 register after reset", rv, 32'd0);
    end
    check("R12 irq after reset", {31'd0, irq}, 32'd0);
    check("R12 busReq after reset", {31'd0, busReq}, 32'd0);

    // R1 requests while disabled, and enabling with zero count
    regWrite(3'd0, mkCtrl(0, 1, 1, 0, 0, 1, 1, 1, 0, 5));
    r0 = nRd;
    pulse(5);
    check("R1 no bus while disabled", nRd - r0, 0);
    regWrite(3'd0, mkCtrl(1, 1, 1, 0, 0, 1, 1, 1, 0, 5));
    regRead(3'd0, rv);
    check("R1 zero count enable ignored", {31'd0, rv[0]}, 32'd0);

    // directed halfword run on line 5
    regWrite(3'd1, 32'd2);
    regWrite(3'd2, 32'h4001_2400);
    regWrite(3'd3, 32'h2000_0100);
    regWrite(3'd0, mkCtrl(1, 1, 1, 0, 0, 1, 1, 1, 0, 5));
    regRead(3'd1, rv);
    check("R5 count loaded on enable", rv, 32'd2);

    // R2 other line ignored
    r0 = nRd;
    pulse(2);
    check("R2 unselected line ignored", nRd - r0, 0);

    // R11 locked configuration
    regWrite(3'd2, 32'h1111_0000);
    regRead(3'd2, rv);
    check("R11 address write locked", rv, 32'h4001_2400);
    regWrite(3'd1, 32'd9);
    regRead(3'd1, rv);
    check("R11 count write locked", rv, 32'd2);
    regWrite(3'd0, mkCtrl(1, 1, 1, 0, 0, 1, 1, 1, 0, 2));
    regRead(3'd0, rv);
    check("R11 channel write locked", {29'd0, rv[13:11]}, 32'd5);

    r0 = nRd; w0 = nWr;
    pulse(5);
    regRead(3'd1, rv);
    check("R5 count after one item", rv, 32'd1);
    pulse(5);
    check("R3 fixed peripheral address", rdA[r0+1], 32'h4001_2400);
    check("R3 halfword memory step", wrA[w0+1], 32'h2000_0102);
    check("R4 halfword data", wrD[w0+1], rdD[r0+1] & 32'hFFFF);
    regRead(3'd4, rv);
    check("R6 completion flag set", rv, 32'd1);
    check("R9 irq from completion", {31'd0, irq}, 32'd1);

    // R10 clear only the named flag
    regWrite(3'd5, 32'd2);
    regRead(3'd4, rv);
    check("R10 error clear leaves completion", rv, 32'd1);
    regWrite(3'd5, 32'd0);
    regRead(3'd4, rv);
    check("R10 zero write keeps flag", rv, 32'd1);
    regWrite(3'd5, 32'd1);
    regRead(3'd4, rv);
    check("R10 completion cleared", rv, 32'd0);
    check("R9 irq low after clear", {31'd0, irq}, 32'd0);

    // R8 read error
    regWrite(3'd1, 32'd3);
    regWrite(3'd0, mkCtrl(1, 0, 1, 0, 0, 1, 2, 2, 0, 1));
    errArm = 1;
    r0 = nRd; w0 = nWr;
    pulse(1);
    check("R8 no write after failed read", nWr - w0, 0);
    regRead(3'd4, rv);
    check("R8 error flag", rv, 32'd2);
    regRead(3'd0, rv);
    check("R8 enable cleared", {31'd0, rv[0]}, 32'd0);
    regRead(3'd1, rv);
    check("R8 count unchanged", rv, 32'd3);
    check("R9 irq from error", {31'd0, irq}, 32'd1);
    regWrite(3'd5, 32'd2);
    check("R9 irq low after error clear", {31'd0, irq}, 32'd0);

    // R8 write error
    regWrite(3'd0, mkCtrl(1, 0, 1, 0, 0, 1, 2, 2, 0, 1));
    errArm = 2;
    pulse(1);
    regRead(3'd4, rv);
    check("R8 error on write phase", rv, 32'd2);
    regRead(3'd1, rv);
    check("R8 count kept on write error", rv, 32'd3);
    regWrite(3'd5, 32'd2);

    // R11 disable write clears enable only
    regWrite(3'd0, mkCtrl(1, 0, 1, 0, 0, 1, 2, 2, 0, 1));
    regWrite(3'd0, 32'd0);
    regRead(3'd0, rv);
    check("R11 disable write", rv, mkCtrl(0, 0, 1, 0, 0, 1, 2, 2, 0, 1));
    r0 = nRd;
    pulse(1);
    check("R1 no bus after disable", nRd - r0, 0);

    // random configurations
    for (int i = 0; i < 24; i++) runRandom(i);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule